// File: doc/BRIEF.md
# Serial ADC Frame Sampling Controller

This block drives a 12-bit serial analog-to-digital converter from a single, faster system clock. It produces the converter's serial clock as an exact divide-by-eight of the system clock with a fixed phase. It also produces the active-low chip select and a serial line that carries the channel address into the converter. It reads the converter's serial data line and assembles each conversion result. Nothing runs in a second clock domain. All state advances on the system clock, and one-cycle strobes mark where the serial clock rises and falls.

A conversion frame is sixteen serial clock periods long. The first four bits of a frame are leading zeros and are thrown away. The next twelve arrive most significant bit first. When the last bit has been taken, the block raises a ready strobe for one system clock cycle. On the same edge it updates an 8-bit sample output with the upper eight bits of the result. Downstream logic uses the strobe as a clock enable. At 25.6 MHz this gives 200 thousand samples per second. The channel address is a parameter and defaults to channel 0.

Top module: `adc_frame_sampler`

## Requirements
- R1: Once running, `adc_sclk` is the system clock divided by `DIV` (default 8). It is low for `DIV/2` cycles, then high for `DIV/2` cycles, and repeats without gaps.
- R2: While `rst` is high, `adc_cs_n` and `adc_sclk` are both 1. `adc_cs_n` goes to 0 on the first clock edge after reset is released and then stays 0. The first falling edge of `adc_sclk` follows `DIV/2` cycles after `adc_cs_n` goes low.
- R3: The frame bit index starts at 0 on the serial clock period that follows each falling edge, counting from the first fall after reset. `adc_sdo` is sampled on the system clock edge where `adc_sclk` goes high. Frame bits 0 to 3 are discarded. Frame bits 4 to 15 form the 12-bit result, with bit 4 the most significant and bit 15 the least significant.
- R4: `sample_valid` is high for exactly one cycle per frame. It rises on the edge where `adc_sclk` goes high for frame bit 15, so pulses come every `16*DIV` cycles (128 by default).
- R5: `sample` takes result bits [11:4] on the same edge that raises `sample_valid`, and keeps that value until the next pulse. It is 0 after reset.
- R6: `adc_sdi` changes only on the edge where `adc_sclk` falls. During frame bits 2, 3 and 4 it carries the 3-bit `CHANNEL` parameter, most significant bit first. At all other bits it is 0. `CHANNEL` defaults to 0.
- R7: A reset applied while frames are running returns every output to its reset value on the next edge: `adc_cs_n`=1, `adc_sclk`=1, `adc_sdi`=0, `sample_valid`=0, `sample`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_sclk | output | 1 | Serial clock to the converter, idle high |
| adc_cs_n | output | 1 | Chip select to the converter, active low |
| adc_sdi | output | 1 | Serial channel address to the converter |
| sample | output | OUT_BITS (8) | Upper bits of the latest conversion result |
| sample_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
Edges are counted from the first edge that sees reset low. Chip select is due after edge 1 and the first serial clock fall after edge 5. After that, falls come at edges 5+8k and rises at 9+8k. The converter bit for rise k is driven half a cycle earlier, and the ready strobe with its new sample is due at edge 129+128f. Every output is compared at the falling system clock edge after each rising edge, against values worked out from this edge count. A second reset in the middle of a frame restarts the count.

// File: rtl/adcfs_pkg.sv
package adcfs_pkg;

    // Sequencer phases: lead-in with chip select low, then free-running frames
    typedef enum logic [0:0] {
        SEQ_LEAD = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_mode_e;

endpackage

// File: rtl/adcfs_sclk_seq.sv
module adcfs_sclk_seq
    import adcfs_pkg::*;
#(
    parameter int DIV        = 8,
    parameter int FRAME_BITS = 16,
    localparam int BIT_W     = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    output logic             sclk,
    output logic             cs_n,
    output logic             rise_stb,
    output logic [BIT_W-1:0] rise_bit,
    output logic             fall_stb,
    output logic [BIT_W-1:0] fall_bit
);
    localparam int HALF   = DIV / 2;
    localparam int PH_W   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HOLD_W = PH_W + 2;

    typedef struct packed {
        seq_mode_e        mode;
        logic [PH_W-1:0]  ph;
        logic [BIT_W-1:0] bitn;
        logic             sclk;
        logic             cs_n;
    } seq_state_t;

    seq_state_t seq_d, seq_q;

    always_comb begin
        seq_d    = seq_q;
        rise_stb = 1'b0;
        fall_stb = 1'b0;
        case (seq_q.mode)
            SEQ_LEAD: begin
                seq_d.cs_n = 1'b0;
                if (!seq_q.cs_n) begin
                    if (seq_q.ph == PH_W'(HALF - 1)) begin
                        fall_stb   = 1'b1;
                        seq_d.mode = SEQ_RUN;
                        seq_d.ph   = '0;
                        seq_d.bitn = '0;
                        seq_d.sclk = 1'b0;
                    end else begin
                        seq_d.ph = seq_q.ph + PH_W'(1);
                    end
                end
            end
            default: begin
                if (seq_q.ph == PH_W'(HALF - 1)) begin
                    rise_stb   = 1'b1;
                    seq_d.sclk = 1'b1;
                    seq_d.ph   = seq_q.ph + PH_W'(1);
                end else if (seq_q.ph == PH_W'(DIV - 1)) begin
                    fall_stb   = 1'b1;
                    seq_d.sclk = 1'b0;
                    seq_d.ph   = '0;
                    seq_d.bitn = (seq_q.bitn == BIT_W'(FRAME_BITS - 1)) ?
                                 '0 : seq_q.bitn + BIT_W'(1);
                end else begin
                    seq_d.ph = seq_q.ph + PH_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.mode <= SEQ_LEAD;
            seq_q.ph   <= '0;
            seq_q.bitn <= '0;
            seq_q.sclk <= 1'b1;
            seq_q.cs_n <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign sclk     = seq_q.sclk;
    assign cs_n     = seq_q.cs_n;
    assign rise_bit = seq_q.bitn;
    assign fall_bit = seq_d.bitn;

    // Checker state: how long the previous serial clock level lasted
    logic [HOLD_W-1:0] hold_q;
    logic              prev_sclk_q;
    logic              armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q      <= '0;
            prev_sclk_q <= 1'b1;
            armed_q     <= 1'b0;
        end else begin
            prev_sclk_q <= sclk;
            if (sclk != prev_sclk_q) begin
                hold_q <= HOLD_W'(1);
                if (!sclk) armed_q <= 1'b1;
            end else if (hold_q != '1) begin
                hold_q <= hold_q + HOLD_W'(1);
            end
        end
    end

    // R1
    sclk_half_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk != prev_sclk_q && armed_q) |-> (hold_q == HOLD_W'(HALF)));

    // R2
    cs_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> sclk);

    // R2
    cs_stays_low_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_n |=> !cs_n);

    // R1
    edge_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(rise_stb && fall_stb));

endmodule

// File: rtl/adcfs_capture.sv
module adcfs_capture #(
    parameter int DIV        = 8,
    parameter int LEAD_BITS  = 4,
    parameter int RES_BITS   = 12,
    parameter int OUT_BITS   = 8,
    localparam int FRAME_BITS = LEAD_BITS + RES_BITS,
    localparam int BIT_W      = $clog2(FRAME_BITS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rise_stb,
    input  logic [BIT_W-1:0]    rise_bit,
    input  logic                din,
    output logic [OUT_BITS-1:0] sample,
    output logic                ready
);
    localparam int PERIOD = FRAME_BITS * DIV;
    localparam int GAP_W  = $clog2(PERIOD) + 2;

    typedef struct packed {
        logic [RES_BITS-1:0] shift;
        logic [OUT_BITS-1:0] sample;
        logic                ready;
    } cap_state_t;

    cap_state_t cap_d, cap_q;
    logic [RES_BITS-1:0] shifted;

    always_comb begin
        cap_d       = cap_q;
        cap_d.ready = 1'b0;
        shifted     = {cap_q.shift[RES_BITS-2:0], din};
        if (rise_stb && (rise_bit >= BIT_W'(LEAD_BITS))) begin
            cap_d.shift = shifted;
            if (rise_bit == BIT_W'(FRAME_BITS - 1)) begin
                cap_d.ready  = 1'b1;
                cap_d.sample = shifted[RES_BITS-1 -: OUT_BITS];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign sample = cap_q.sample;
    assign ready  = cap_q.ready;

    // Checker state: cycles since the previous ready pulse
    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (ready) begin
            gap_q  <= GAP_W'(1);
            seen_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + GAP_W'(1);
        end
    end

    // R4
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    // R4
    frame_period_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && seen_q) |-> (gap_q == GAP_W'(PERIOD)));

    // R5
    sample_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ready |-> $stable(sample));

endmodule

// File: rtl/adcfs_addr_out.sv
module adcfs_addr_out #(
    parameter int FRAME_BITS = 16,
    parameter int ADDR_BITS  = 3,
    parameter int ADDR_FIRST = 2,
    parameter int CHANNEL    = 0,
    localparam int BIT_W     = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fall_stb,
    input  logic [BIT_W-1:0] fall_bit,
    output logic             dout
);
    localparam logic [ADDR_BITS-1:0] CH_VEC = ADDR_BITS'(CHANNEL);

    typedef struct packed {
        logic dout;
    } addr_state_t;

    addr_state_t addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (fall_stb) begin
            addr_d.dout = 1'b0;
            for (int i = 0; i < ADDR_BITS; i++) begin
                if (fall_bit == BIT_W'(ADDR_FIRST + i)) begin
                    addr_d.dout = CH_VEC[ADDR_BITS-1-i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign dout = addr_q.dout;

    // R6
    addr_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !fall_stb |=> $stable(dout));

endmodule

// File: rtl/adc_frame_sampler.sv
module adc_frame_sampler #(
    parameter int DIV        = 8,
    parameter int LEAD_BITS  = 4,
    parameter int RES_BITS   = 12,
    parameter int OUT_BITS   = 8,
    parameter int ADDR_BITS  = 3,
    parameter int ADDR_FIRST = 2,
    parameter int CHANNEL    = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                adc_sdo,
    output logic                adc_sclk,
    output logic                adc_cs_n,
    output logic                adc_sdi,
    output logic [OUT_BITS-1:0] sample,
    output logic                sample_valid
);
    localparam int FRAME_BITS = LEAD_BITS + RES_BITS;
    localparam int BIT_W      = $clog2(FRAME_BITS);

    if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
        $error("DIV must be even and at least 2");
    end
    if (OUT_BITS > RES_BITS || ADDR_FIRST + ADDR_BITS > FRAME_BITS) begin : g_bad_fields
        $error("field widths do not fit the frame");
    end

    logic             rise_stb;
    logic             fall_stb;
    logic [BIT_W-1:0] rise_bit;
    logic [BIT_W-1:0] fall_bit;

    adcfs_sclk_seq #(
        .DIV        (DIV),
        .FRAME_BITS (FRAME_BITS)
    ) i_seq (
        .clk      (clk),
        .rst      (rst),
        .sclk     (adc_sclk),
        .cs_n     (adc_cs_n),
        .rise_stb (rise_stb),
        .rise_bit (rise_bit),
        .fall_stb (fall_stb),
        .fall_bit (fall_bit)
    );

    adcfs_capture #(
        .DIV       (DIV),
        .LEAD_BITS (LEAD_BITS),
        .RES_BITS  (RES_BITS),
        .OUT_BITS  (OUT_BITS)
    ) i_cap (
        .clk      (clk),
        .rst      (rst),
        .rise_stb (rise_stb),
        .rise_bit (rise_bit),
        .din      (adc_sdo),
        .sample   (sample),
        .ready    (sample_valid)
    );

    adcfs_addr_out #(
        .FRAME_BITS (FRAME_BITS),
        .ADDR_BITS  (ADDR_BITS),
        .ADDR_FIRST (ADDR_FIRST),
        .CHANNEL    (CHANNEL)
    ) i_addr (
        .clk      (clk),
        .rst      (rst),
        .fall_stb (fall_stb),
        .fall_bit (fall_bit),
        .dout     (adc_sdi)
    );

endmodule

// File: tb/test_adc_frame_sampler.sv
module test_adc_frame_sampler;
    localparam int CH = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sdo = 1'b0;
    logic       sclk, cs_n, sdi, valid;
    logic [7:0] sample;

    always #4 clk = ~clk;

    adc_frame_sampler #(.CHANNEL(CH)) i_adc_frame_sampler (
        .clk          (clk),
        .rst          (rst),
        .adc_sdo      (sdo),
        .adc_sclk     (sclk),
        .adc_cs_n     (cs_n),
        .adc_sdi      (sdi),
        .sample       (sample),
        .sample_valid (valid)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int n        = 0;
    int base     = 0;
    logic [11:0] words [16];
    logic [3:0]  junk  [16];

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s edge %0d: actual %0h expected %0h", req, n, act, exp);
        end
    endtask

    function automatic logic exp_sclk(input int e);
        if (e < 5) return 1'b1;
        return ((e - 5) % 8) >= 4;
    endfunction

    function automatic logic exp_sdi(input int e);
        int b;
        if (e < 5) return 1'b0;
        b = ((e - 5) / 8) % 16;
        if (b >= 2 && b <= 4) return CH[2 - (b - 2)];
        return 1'b0;
    endfunction

    function automatic logic exp_valid(input int e);
        return (e >= 129) && (((e - 129) % 128) == 0);
    endfunction

    function automatic logic [7:0] exp_sample(input int e, input int bs);
        if (e < 129) return 8'h00;
        return words[bs + (e - 129) / 128][11:4];
    endfunction

    // Converter model: present the bit for the next rising serial clock edge
    task automatic drive_next();
        int e = n + 1;
        if (e >= 9 && ((e - 9) % 8) == 0) begin
            int k = (e - 9) / 8;
            int f = k / 16;
            int b = k % 16;
            sdo = (b < 4) ? junk[base + f][b] : words[base + f][15 - b];
        end
    endtask

    task automatic reset_checks(input string tag);
        check(cs_n == 1'b1, {tag, " cs_n"}, cs_n, 1);
        check(sclk == 1'b1, {tag, " sclk"}, sclk, 1);
        check(sdi == 1'b0, {tag, " sdi"}, sdi, 0);
        check(valid == 1'b0, {tag, " valid"}, valid, 0);
        check(sample == 8'h00, {tag, " sample"}, sample, 0);
    endtask

    task automatic run(input int cycles);
        n = 0;
        drive_next();
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            n++;
            check(cs_n == 1'b0, "R2 cs_n low", cs_n, 0);
            if (n < 5) check(sclk == exp_sclk(n), "R2 lead-in sclk", sclk, exp_sclk(n));
            else       check(sclk == exp_sclk(n), "R1 sclk", sclk, exp_sclk(n));
            check(sdi == exp_sdi(n), "R6 address", sdi, exp_sdi(n));
            check(valid == exp_valid(n), "R4 ready", valid, exp_valid(n));
            check(sample == exp_sample(n, base), "R3 R5 sample", sample, exp_sample(n, base));
            drive_next();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 16; i++) begin
            words[i] = 12'($urandom);
            junk[i]  = 4'($urandom);
        end
        // directed corners; leading junk must be discarded (R3)
        words[0] = 12'h000; junk[0] = 4'hF;
        words[1] = 12'hFFF; junk[1] = 4'h0;
        words[2] = 12'h800;
        words[3] = 12'h00F; junk[3] = 4'hF;
        words[4] = 12'h7F0;
        words[8] = 12'hFFF; junk[8] = 4'hA;

        repeat (4) @(negedge clk);
        reset_checks("R2 R7 initial reset");
        rst  = 1'b0;
        base = 0;
        run(129 + 128 * 6 + 60);

        // reset in the middle of a frame
        rst = 1'b1;
        sdo = 1'b1;
        @(negedge clk);
        reset_checks("R7 mid-run reset");
        repeat (2) @(negedge clk);
        reset_checks("R7 held reset");
        rst  = 1'b0;
        base = 8;
        run(129 + 128 * 6 + 10);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule